// File: doc/BRIEF.md
# MDIO Clause-22 Gateway Master

This block drives a PHY management bus as a master. Software composes a complete
management transaction in one 32-bit gateway word. That word holds the PHY
address, the register address, an opcode, a start flag, a 16-bit data field and a
busy flag. Software launches the transaction by writing the word with busy set.
The block serialises a Clause-22 frame on the management clock and data lines. It
then clears busy. For a read, it also places the 16 bits it captured from the PHY
into the data field of the same word, so the value software polls for completion
is also the read result.

A second word sets the timing, counted in core clocks:

- the half-period of the management clock;
- the phase inside each management clock cycle at which the next frame bit is put on the line;
- the phase at which read data is sampled.

Writing an all-zero gateway word while a transaction is in progress abandons the
transaction at once.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the gateway word reads 0, the config word reads 32'h0D06_0900 (period 9, sample 6, drive 13), MDC is low and the output enable is low.
- R2: Register address 0 selects the gateway word. Its fields are data [15:0], register [20:16], PHY [25:21], opcode [27:26] (1 write, 2 read), start [28] and busy [30]. Bits 29 and 31 read 0. A write with busy=1, start=1 and opcode 1 or 2 launches a frame, and busy then reads 1 until the frame ends.
- R3: A frame is 64 MDC cycles with bits sent MSB first. It consists of 32 ones, then 01, the opcode, the PHY address and the register address. A write continues with a turnaround of 10 and the 16 data bits.
- R4: MDC is low while no frame is running. One MDC cycle is 2*(period+1) core clocks, low half first. The first rising edge comes period+1 core clocks after the launching write.
- R5: Each frame bit changes at the drive phase of its MDC cycle. A read data bit is taken at the sample phase of its MDC cycle.
- R6: In a read, the output enable falls from the turnaround bit onward. What the PHY drives during turnaround is ignored. On completion the 16 sampled bits, first bit in bit 15, replace gateway bits [15:0], the other fields are kept and busy clears.
- R7: When a write frame completes, busy clears, the other gateway bits are unchanged and the output enable falls.
- R8: A busy=1 write with opcode 0 or 3, or with start=0, is stored with busy already clear on the next cycle and produces no MDC edge.
- R9: While busy, any non-zero gateway write is ignored and the frame continues unchanged.
- R10: An all-zero gateway write while busy makes the gateway word 0 on the next cycle, with MDC and the output enable low.
- R11: Register address 1 selects the config word: period [15:8], sample phase [23:16], drive phase [31:24]. Bits [7:0] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrEn | input | 1 | register write strobe |
| regAddr | input | 1 | 0 gateway word, 1 config word |
| regWrData | input | 32 | register write value |
| regRdData | output | 32 | selected register value |
| mdc | output | 1 | management clock |
| mdioOut | output | 1 | management data driven by the block |
| mdioOe | output | 1 | output enable for mdioOut |
| mdioIn | input | 1 | management data from the line |

## Verification
The assertions assume the following about the inputs:

- The config word is not rewritten while a frame runs.
- Both phase values lie below the last phase of an MDC cycle.
- The sample phase falls after the rising edge of MDC.

Under these assumptions, frame bits and captured data line up with MDC cycles. The stimulus reprograms the timing only while the block is idle. It uses two settings that keep the drive phase in the low half and the sample phase in the high half. The PHY model changes its data just after each rising edge it observes, so the value is stable at the sample phase.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 8;

  localparam int BUSY_BIT  = 30;
  localparam int START_BIT = 28;
  localparam logic [WORD_W-1:0] GW_KEEP_MASK = 32'h5FFF_FFFF;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } mdioOp_e;

  typedef struct packed {
    logic drive;     // put next frame bit on the line
    logic capture;   // take one read data bit
    logic floatBus;  // current bit belongs to the PHY
    logic finish;    // last MDC cycle ends
  } ctrlStrobe_t;
endpackage

// File: rtl/mdio_gw_ctrl.sv
module mdio_gw_ctrl
  import mdio_gw_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int TA_IDX    = 46,
  parameter int DATA_IDX  = 48,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int PH_W     = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               launch,
  input  logic               abort,
  input  logic               isRead,
  input  logic [FIELD_W-1:0] period,
  input  logic [FIELD_W-1:0] inPt,
  input  logic [FIELD_W-1:0] outPt,
  output ctrlStrobe_t        strobe,
  output logic               active,
  output logic               mdc,
  output logic [IDX_W-1:0]   bitCnt
);
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] halfLen;
  logic [PH_W-1:0] lastPh;
  logic            cycleEnd;
  logic            lastBit;

  assign halfLen  = {2'b00, period} + PH_W'(1);
  assign lastPh   = {halfLen[PH_W-2:0], 1'b0} - PH_W'(1);
  assign cycleEnd = active && (phase == lastPh);
  assign lastBit  = (bitCnt == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (abort) begin
      active <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (launch) begin
      active <= 1'b1;
      phase  <= '0;
      bitCnt <= '0;
    end else if (active) begin
      if (cycleEnd) begin
        phase <= '0;
        if (lastBit) begin
          active <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + IDX_W'(1);
        end
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    strobe.drive    = active && (phase == {2'b00, outPt});
    strobe.capture  = active && (phase == {2'b00, inPt}) && isRead &&
                      (bitCnt >= IDX_W'(DATA_IDX));
    strobe.floatBus = isRead && (bitCnt >= IDX_W'(TA_IDX));
    strobe.finish   = cycleEnd && lastBit;
  end

  assign mdc = active && (phase >= halfLen);
endmodule

// File: rtl/mdio_gw_dp.sv
module mdio_gw_dp
  import mdio_gw_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int DEF_PERIOD = 9,
  parameter int DEF_IN     = 6,
  parameter int DEF_OUT    = 13,
  localparam int FRAME_LEN = PRE_LEN + 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  ctrlStrobe_t        strobe,
  input  logic               mdioIn,
  output logic               launch,
  output logic               abort,
  output logic               isRead,
  output logic               busy,
  output logic [WORD_W-1:0]  gwWord,
  output logic [FIELD_W-1:0] period,
  output logic [FIELD_W-1:0] inPt,
  output logic [FIELD_W-1:0] outPt,
  output logic               mdioOut,
  output logic               mdioOe
);
  localparam int CFG_W = 3 * FIELD_W;

  logic [CFG_W-1:0]     cfgQ;
  logic [FRAME_LEN-1:0] frameSh;
  logic [15:0]          capSh;
  logic                 gwWrite;
  logic                 cfgWrite;
  logic                 wantBusy;
  logic                 validCmd;
  mdioOp_e              wrOp;
  logic [1:0]           taBits;
  logic [15:0]          txData;

  assign gwWrite  = regWrEn && !regAddr;
  assign cfgWrite = regWrEn && regAddr;
  assign wrOp     = mdioOp_e'(regWrData[27:26]);
  assign wantBusy = regWrData[BUSY_BIT];
  assign validCmd = regWrData[START_BIT] && (wrOp == OP_WRITE || wrOp == OP_READ);
  assign abort    = gwWrite && busy && (regWrData == '0);
  assign launch   = gwWrite && !busy && wantBusy && validCmd;
  assign busy     = gwWord[BUSY_BIT];
  assign isRead   = (mdioOp_e'(gwWord[27:26]) == OP_READ);
  assign taBits   = (wrOp == OP_READ) ? 2'b11 : 2'b10;
  assign txData   = (wrOp == OP_READ) ? 16'hFFFF : regWrData[15:0];

  // gateway word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gwWord <= '0;
    end else if (abort) begin
      gwWord <= '0;
    end else if (gwWrite && !busy) begin
      gwWord           <= regWrData & GW_KEEP_MASK;
      gwWord[BUSY_BIT] <= wantBusy && validCmd;
    end else if (strobe.finish) begin
      gwWord[BUSY_BIT] <= 1'b0;
      if (isRead) gwWord[15:0] <= capSh;
    end
  end

  // timing word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= {FIELD_W'(DEF_OUT), FIELD_W'(DEF_IN), FIELD_W'(DEF_PERIOD)};
    end else if (cfgWrite) begin
      cfgQ <= regWrData[WORD_W-1:FIELD_W];
    end
  end

  assign period = cfgQ[FIELD_W-1:0];
  assign inPt   = cfgQ[2*FIELD_W-1:FIELD_W];
  assign outPt  = cfgQ[CFG_W-1:2*FIELD_W];

  // frame shifter and line driver
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSh <= '1;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else if (abort || strobe.finish) begin
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else if (launch) begin
      frameSh <= {{PRE_LEN{1'b1}}, 2'b01, regWrData[27:26], regWrData[25:21],
                  regWrData[20:16], taBits, txData};
    end else if (strobe.drive) begin
      mdioOut <= frameSh[FRAME_LEN-1];
      mdioOe  <= !strobe.floatBus;
      frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};
    end
  end

  // read capture, first bit ends up in bit 15
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSh <= '0;
    end else if (strobe.capture) begin
      capSh <= {capSh[14:0], mdioIn};
    end
  end

  assign regRdData = regAddr ? {cfgQ, {FIELD_W{1'b0}}} : gwWord;
endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
  import mdio_gw_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int DEF_PERIOD = 9,
  parameter int DEF_IN     = 6,
  parameter int DEF_OUT    = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  ctrlStrobe_t        strobe;
  logic               launch;
  logic               abort;
  logic               isRead;
  logic               busy;
  logic               active;
  logic [IDX_W-1:0]   bitCnt;
  logic [WORD_W-1:0]  gwWord;
  logic [FIELD_W-1:0] period;
  logic [FIELD_W-1:0] inPt;
  logic [FIELD_W-1:0] outPt;

  mdio_gw_ctrl #(
    .FRAME_LEN(FRAME_LEN), .TA_IDX(TA_IDX), .DATA_IDX(DATA_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .launch(launch), .abort(abort), .isRead(isRead),
    .period(period), .inPt(inPt), .outPt(outPt), .strobe(strobe),
    .active(active), .mdc(mdc), .bitCnt(bitCnt)
  );

  mdio_gw_dp #(
    .PRE_LEN(PRE_LEN), .DEF_PERIOD(DEF_PERIOD), .DEF_IN(DEF_IN), .DEF_OUT(DEF_OUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .mdioIn(mdioIn), .launch(launch), .abort(abort), .isRead(isRead),
    .busy(busy), .gwWord(gwWord), .period(period), .inPt(inPt), .outPt(outPt),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_gw_checker.sv
module mdio_gw_checker #(
  parameter int IDX_W  = 6,
  parameter int TA_IDX = 46
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [31:0]      regWrData,
  input logic [31:0]      gwWord,
  input logic             busy,
  input logic             active,
  input logic [IDX_W-1:0] bitCnt,
  input logic             mdc,
  input logic             mdioOe
);
  assert_busy_tracks_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy == active);

  assert_idle_lines_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_read_bus_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && gwWord[27:26] == 2'd2 && bitCnt >= IDX_W'(TA_IDX + 1)) |-> !mdioOe);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && !regAddr && regWrData != 32'd0) |=> $stable(gwWord[28:16]));

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && !regAddr && regWrData == 32'd0) |=>
      (gwWord == 32'd0 && !mdc && !mdioOe && !active));
endmodule

bind mdio_gw_master mdio_gw_checker #(.IDX_W(IDX_W), .TA_IDX(TA_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .gwWord(gwWord), .busy(busy), .active(active),
  .bitCnt(bitCnt), .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/mdio_gw_master_bench.sv
`timescale 1ns/1ps
module mdio_gw_master_bench;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int total = 0;
  int bad = 0;

  mdio_gw_master u_mdio_gw_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #(HALF) clk = ~clk;

  // scoreboard queues
  logic [63:0] expBitsQ[$];
  logic [63:0] expOeQ[$];
  logic [15:0] phyData = 16'h0000;

  // monitor state
  int          bitsSeen = 0;
  int          riseCount = 0;
  int          clkSinceRise = 0;
  int          lastPeriod = 0;
  logic        prevMdc = 1'b0;
  logic [63:0] obsBits = '0;
  logic [63:0] obsOe = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] op, input logic start,
                                        input logic [4:0] phy, input logic [4:0] rg,
                                        input logic [15:0] dat);
    return {1'b0, 1'b1, 1'b0, start, op, phy, rg, dat};
  endfunction

  // driver side: push the frame the PHY should see
  task automatic pushFrame(input logic [31:0] cmd);
    logic [1:0]  op;
    logic [63:0] bits;
    op   = cmd[27:26];
    bits = {32'hFFFF_FFFF, 2'b01, op, cmd[25:21], cmd[20:16],
            (op == 2'd2) ? 2'b11 : 2'b10, cmd[15:0]};
    expBitsQ.push_back(bits);
    expOeQ.push_back((op == 2'd2) ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
  endtask

  // monitor and PHY model
  always @(negedge clk) begin
    clkSinceRise <= clkSinceRise + 1;
    prevMdc <= mdc;
    if (mdc && !prevMdc) begin
      riseCount <= riseCount + 1;
      if (bitsSeen > 0) lastPeriod <= clkSinceRise;
      clkSinceRise <= 1;
      if (bitsSeen < 64) begin
        obsBits[63-bitsSeen] = mdioOut;
        obsOe[63-bitsSeen]   = mdioOe;
        if (bitsSeen >= 48)      mdioIn <= phyData[63-bitsSeen];
        else if (bitsSeen >= 46) mdioIn <= 1'b0;
        else                     mdioIn <= 1'b1;
        bitsSeen = bitsSeen + 1;
        if (bitsSeen == 64) begin
          if (expBitsQ.size() == 0) begin
            check(1'b0, "R3 unexpected frame", obsBits, 64'd0);
          end else begin
            logic [63:0] eb, eo;
            eb = expBitsQ.pop_front();
            eo = expOeQ.pop_front();
            check((obsBits & eo) == (eb & eo), "R3 frame bits", obsBits & eo, eb & eo);
            check(obsOe == eo, "R6 output enable pattern", obsOe, eo);
          end
          bitsSeen = 0;
        end
      end
    end
  end

  task automatic regWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic waitIdle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      regRead(1'b0, v);
      if (!v[30]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic firstRise(input int expN);
    int n;
    n = 0;
    while (!mdc && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == expN, "R4 first rise after launch", n, expN);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, cmd, cmd2;
    bit ok;
    int rises;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(1'b0, v);
    check(v == 32'd0, "R1 gateway reset", v, 0);
    regRead(1'b1, v);
    check(v == 32'h0D06_0900, "R1 config reset", v, 32'h0D06_0900);
    check(!mdc && !mdioOe, "R1 lines at reset", {mdc, mdioOe}, 0);

    // R11: timing word, period 4, sample 7, drive 1
    regWrite(1'b1, 32'h0107_04FF);
    regRead(1'b1, v);
    check(v == 32'h0107_0400, "R11 config readback", v, 32'h0107_0400);

    // R2 R3 R4 R7 R9: write frame
    cmd = mkCmd(2'd1, 1'b1, 5'h11, 5'h04, 16'hA5C3);
    pushFrame(cmd);
    regWrite(1'b0, cmd);
    regRead(1'b0, v);
    check(v == cmd, "R2 busy set after launch", v, cmd);
    firstRise(5);
    cmd2 = mkCmd(2'd2, 1'b1, 5'h02, 5'h1F, 16'h0F0F);
    regWrite(1'b0, cmd2);
    regRead(1'b0, v);
    check(v == cmd, "R9 write while busy ignored", v, cmd);
    waitIdle(ok);
    check(ok, "R2 busy clears", ok, 1);
    regRead(1'b0, v);
    check(v == (cmd & 32'h1FFF_FFFF), "R7 write completion word", v, cmd & 32'h1FFF_FFFF);
    check(!mdioOe && !mdc, "R7 lines released", {mdc, mdioOe}, 0);
    check(lastPeriod == 10, "R4 MDC period p=4", lastPeriod, 10);

    // R5 R6: read frame
    phyData = 16'h3C96;
    cmd = mkCmd(2'd2, 1'b1, 5'h03, 5'h1E, 16'h1234);
    pushFrame(cmd);
    regWrite(1'b0, cmd);
    waitIdle(ok);
    regRead(1'b0, v);
    check(v == ((cmd & 32'h1FFF_0000) | 32'h3C96), "R6 read data returned",
          v, (cmd & 32'h1FFF_0000) | 32'h3C96);

    // R4 R5: faster timing, period 2, sample 4, drive 0
    regWrite(1'b1, 32'h0004_0200);
    phyData = 16'h8001;
    cmd = mkCmd(2'd2, 1'b1, 5'h1F, 5'h00, 16'h0000);
    pushFrame(cmd);
    regWrite(1'b0, cmd);
    firstRise(3);
    waitIdle(ok);
    regRead(1'b0, v);
    check(v == ((cmd & 32'h1FFF_0000) | 32'h8001), "R5 read sample at phase",
          v, (cmd & 32'h1FFF_0000) | 32'h8001);
    check(lastPeriod == 6, "R4 MDC period p=2", lastPeriod, 6);

    // R8: no-frame commands
    for (int k = 0; k < 3; k++) begin
      logic [31:0] bc;
      bc = (k == 0) ? mkCmd(2'd0, 1'b1, 5'h01, 5'h01, 16'h1111) :
           (k == 1) ? mkCmd(2'd3, 1'b1, 5'h02, 5'h02, 16'h2222) :
                      mkCmd(2'd1, 1'b0, 5'h03, 5'h03, 16'h3333);
      rises = riseCount;
      regWrite(1'b0, bc);
      regRead(1'b0, v);
      check(v == (bc & 32'h1FFF_FFFF), "R8 busy clear at once", v, bc & 32'h1FFF_FFFF);
      repeat (20) @(negedge clk);
      check(riseCount == rises, "R8 no MDC edge", riseCount, rises);
    end

    // R10: abort mid frame, no expectation pushed
    cmd = mkCmd(2'd1, 1'b1, 5'h0A, 5'h05, 16'hFFFF);
    regWrite(1'b0, cmd);
    repeat (100) @(negedge clk);
    regWrite(1'b0, 32'd0);
    bitsSeen = 0;
    regRead(1'b0, v);
    check(v == 32'd0, "R10 abort clears word", v, 0);
    check(!mdc && !mdioOe, "R10 abort lines low", {mdc, mdioOe}, 0);

    // R3 R4: fresh frame after abort
    cmd = mkCmd(2'd1, 1'b1, 5'h15, 5'h0A, 16'h0001);
    pushFrame(cmd);
    regWrite(1'b0, cmd);
    firstRise(3);
    waitIdle(ok);
    check(ok, "R3 frame after abort completes", ok, 1);

    repeat (10) @(negedge clk);
    check(expBitsQ.size() == 0, "R3 all frames seen", expBitsQ.size(), 0);
    summary();
    $finish;
  end
endmodule